// File: doc/BRIEF.md
# Indexed Block Configuration Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus (I2C) target that holds 24 byte-wide configuration registers for a clock controller. It runs on a fast system clock and sees SCL and SDA as already-synchronised samples. From these samples it detects start, repeated-start and stop conditions and the edges of the serial clock. It drives the data line only through an open-drain pull-low enable.

A host writes by addressing the target, giving a starting index and then a byte count, and then sending the data. Each accepted byte lands in the next register. To read, the host gives the index in a write phase and then issues a repeated start with the read address. The target first returns a count byte, taken from a writable count register, and then the register contents from the index onward. It keeps sending as long as the host acknowledges.

The rest of the chip sees the whole bank as one flat parallel bus. Five strap inputs show up live as read-only bits of one register. Some bits are fixed or reserved and keep their values whatever the host writes.

Top module: `i2c_indexed_cfg_slave`

## Requirements
- R1: The target acknowledges the 8-bit address byte 0xD2 (write) and 0xD3 (read). Any other address byte is not acknowledged, and the bytes after it are neither acknowledged nor written, up to the next start.
- R2: A write is carried out as follows. The target acknowledges the address, the index byte N and the count byte X. It then writes the following data bytes into registers N, N+1, … and acknowledges each of them. Register i appears on `cfg_o[8*i+7:8*i]`.
- R3: Once X data bytes have been written, any further data byte in the same transfer is not acknowledged and is not written.
- R4: A read is carried out as follows. The host writes index N and issues a repeated start with 0xD3. The target then sends the count register value, followed by the images of registers N, N+1, … with the MSB first. It continues while the host acknowledges and releases the bus after a not-acknowledge.
- R5: The count register is at index 8. It resets to 0x0F, and a write to it changes the count byte sent on later reads.
- R6: Register 6 always reads 0x01 and register 7 always reads 0x01. Writes to either have no effect.
- R7: Register 1 bits 4:0 always show the current `strap_i` value. Bits 7:5 of register 1 are writable.
- R8: Some bits are reserved. They always read 0, and writes to them have no effect. The reserved bits are register 5 bits 4:0, register 14 bits 7:5 and register 23 bits 7:6.
- R9: Indexes above 23 read as 0x00. Data written to them is dropped but still acknowledged, and the pointer keeps incrementing.
- R10: A stop or a new start in the middle of a transfer ends the transfer. Registers written before that point keep their new values, and no other register changes.
- R11: The data line is only ever pulled low, and the pull-low enable changes only while SCL is low.
- R12: After reset, every register other than those fixed by R5 to R7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock sample |
| sda_i | input | 1 | Synchronised serial data line sample |
| strap_i | input | 5 | Latched strap values, shown in register 1 bits 4:0 |
| sda_pull_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_o | output | 192 | Flat register bank image, register i in bits 8i+7:8i |

## Verification
The hardest states to reach from the pins are those where a transfer is cut short. One is a write that is overtaken by a repeated start and turned into a read. The other is a write whose data runs past its declared count. The stimulus is a bit-level host model that can place a start or stop after any byte and can send more data bytes than it declared. After each such transfer the bench compares the whole flat bank, and the data bytes read back, against a model. That model applies the write masks and fixed bits arithmetically.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int REG_COUNT    = 24;
    localparam int BYTE_W       = 8;
    localparam int IDX_W        = 8;
    localparam int STRAP_W      = 5;
    localparam int IDX_COUNTREG = 8;
    localparam int IDX_STRAP    = 1;
    localparam logic [6:0] TARGET_ADDR7 = 7'h69;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RXB,
        ST_RXACK,
        ST_TXB,
        ST_TXACK
    } link_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl_prev;
    } bus_evt_t;

    // Bits the host may change in each register.
    function automatic byte_t write_mask(int idx);
        case (idx)
            1:       return 8'hE0;
            5:       return 8'hE0;
            6, 7:    return 8'h00;
            14:      return 8'h1F;
            23:      return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

    // Constant identity bits.
    function automatic byte_t fixed_bits(int idx);
        case (idx)
            6, 7:    return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic byte_t reset_value(int idx);
        return (idx == IDX_COUNTREG) ? 8'h0F : 8'h00;
    endfunction

endpackage

// File: rtl/i2cb_busmon.sv
module i2cb_busmon
    import i2cb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.start    = scl_q & scl_i & sda_q & ~sda_i;
        evt.stop     = scl_q & scl_i & ~sda_q & sda_i;
        evt.rise     = ~scl_q & scl_i;
        evt.fall     = scl_q & ~scl_i;
        evt.sda      = sda_i;
        evt.scl_prev = scl_q;
    end

endmodule

// File: rtl/i2cb_bank.sv
module i2cb_bank
    import i2cb_pkg::*;
#(
    parameter int NREG = REG_COUNT,
    parameter int SW   = STRAP_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  byte_t                  wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic [SW-1:0]          strap,
    output byte_t                  rd_data,
    output byte_t                  count_val,
    output logic [NREG*BYTE_W-1:0] bank_o
);

    byte_t image [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam byte_t MASK = write_mask(g);
        localparam byte_t FIX  = fixed_bits(g);
        localparam byte_t RSTV = reset_value(g);
        byte_t store;

        always_ff @(posedge clk) begin
            if (rst)
                store <= RSTV & MASK;
            else if (wr_en && wr_idx == IDX_W'(g))
                store <= (wr_data & MASK) | (store & ~MASK);
        end

        if (g == IDX_STRAP) begin : g_strap
            assign image[g] = (store & MASK) | byte_t'(strap);
        end else begin : g_plain
            assign image[g] = (store & MASK) | FIX;
        end

        assign bank_o[g*BYTE_W +: BYTE_W] = image[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDX_W'(i)) rd_data = image[i];
    end

    assign count_val = image[IDX_COUNTREG];

    // R9: a write aimed past the bank leaves every register untouched
    assert_oob_write_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= IDX_W'(NREG) && $stable(strap)) |=> $stable(bank_o));

endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
    import i2cb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  byte_t            rd_data,
    input  byte_t            count_val,
    output logic [IDX_W-1:0] ptr_o,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output byte_t            wr_data,
    output logic             sda_oe
);

    link_state_e      st;
    rx_phase_e        ph;
    byte_t            sh;
    logic [3:0]       nbits;
    logic [IDX_W-1:0] ptr;
    byte_t            left;
    logic             rd_mode;
    logic             host_ack;

    assign ptr_o = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ph       <= PH_ADDR;
            sh       <= '0;
            nbits    <= '0;
            ptr      <= '0;
            left     <= '0;
            rd_mode  <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                st     <= ST_RXB;
                ph     <= PH_ADDR;
                nbits  <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RXB: begin
                        if (evt.rise) begin
                            sh    <= {sh[BYTE_W-2:0], evt.sda};
                            nbits <= nbits + 4'd1;
                        end else if (evt.fall && nbits == 4'd8) begin
                            nbits <= '0;
                            case (ph)
                                PH_ADDR: begin
                                    if (sh[7:1] == TARGET_ADDR7) begin
                                        rd_mode <= sh[0];
                                        ph      <= PH_INDEX;
                                        sda_oe  <= 1'b1;
                                        st      <= ST_RXACK;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                PH_INDEX: begin
                                    ptr    <= IDX_W'(sh);
                                    ph     <= PH_COUNT;
                                    sda_oe <= 1'b1;
                                    st     <= ST_RXACK;
                                end
                                PH_COUNT: begin
                                    left   <= sh;
                                    ph     <= PH_DATA;
                                    sda_oe <= 1'b1;
                                    st     <= ST_RXACK;
                                end
                                default: begin
                                    if (left != '0) begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= ptr;
                                        wr_data <= sh;
                                        ptr     <= ptr + 1'b1;
                                        left    <= left - 8'd1;
                                        sda_oe  <= 1'b1;
                                        st      <= ST_RXACK;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_RXACK: begin
                        if (evt.fall) begin
                            nbits <= '0;
                            if (rd_mode) begin
                                sh     <= count_val;
                                sda_oe <= ~count_val[BYTE_W-1];
                                st     <= ST_TXB;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RXB;
                            end
                        end
                    end
                    ST_TXB: begin
                        if (evt.fall) begin
                            if (nbits == 4'd7) begin
                                sda_oe <= 1'b0;
                                nbits  <= '0;
                                st     <= ST_TXACK;
                            end else begin
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh[BYTE_W-2];
                                nbits  <= nbits + 4'd1;
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (evt.rise) begin
                            host_ack <= ~evt.sda;
                        end else if (evt.fall) begin
                            host_ack <= 1'b0;
                            if (host_ack) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                ptr    <= ptr + 1'b1;
                                st     <= ST_TXB;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: any start restarts the address phase with the line released
    assert_start_restarts_R10: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (st == ST_RXB && ph == PH_ADDR && !sda_oe));

    // R3: a data byte past the count is neither written nor acknowledged
    assert_count_exhausted_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RXB && ph == PH_DATA && evt.fall && nbits == 4'd8 && left == '0)
        |=> (!wr_en && !sda_oe && st == ST_IDLE));

    // R2: each register write consumes exactly one unit of the count
    assert_count_decrements_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (left == $past(left) - 8'd1));

endmodule

// File: rtl/i2c_indexed_cfg_slave.sv
module i2c_indexed_cfg_slave
    import i2cb_pkg::*;
#(
    parameter int NREG = REG_COUNT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic [STRAP_W-1:0]     strap_i,
    output logic                   sda_pull_low_o,
    output logic [NREG*BYTE_W-1:0] cfg_o
);

    bus_evt_t         evt;
    logic [IDX_W-1:0] ptr;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    byte_t            wr_data;
    byte_t            rd_data;
    byte_t            count_val;

    i2cb_busmon u_busmon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2cb_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .rd_data   (rd_data),
        .count_val (count_val),
        .ptr_o     (ptr),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_pull_low_o)
    );

    i2cb_bank #(.NREG(NREG), .SW(STRAP_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (ptr),
        .strap     (strap_i),
        .rd_data   (rd_data),
        .count_val (count_val),
        .bank_o    (cfg_o)
    );

    // R11: the pull-low enable moves only while SCL was low
    assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_low_o) |-> !evt.scl_prev);

endmodule

// File: tb/tb_i2c_indexed_cfg_slave.sv
module tb_i2c_indexed_cfg_slave;

    localparam int Q    = 4;
    localparam int NREG = 24;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst = 1'b1;
    logic              scl = 1'b1;
    logic              sda_h = 1'b1;
    logic [4:0]        strap = 5'h13;
    logic              oe;
    logic              line;
    logic [NREG*8-1:0] cfg;

    assign line = sda_h & ~oe;

    i2c_indexed_cfg_slave dut (
        .clk            (clk),
        .rst            (rst),
        .scl_i          (scl),
        .sda_i          (line),
        .strap_i        (strap),
        .sda_pull_low_o (oe),
        .cfg_o          (cfg)
    );

    int n_chk = 0;
    int n_bad = 0;
    int sda_viol = 0;
    logic oe_prev = 1'b0;

    logic [7:0] model [NREG];
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];
    logic       ackv [40];
    logic [7:0] cnt_rd;

    // R11 monitor: enable may change only while SCL is low
    always @(negedge clk) begin
        if (!rst && oe !== oe_prev && scl) sda_viol++;
        oe_prev = oe;
    end

    function automatic logic [7:0] mask_of(int i);
        case (i)
            1, 5:    return 8'hE0;
            6, 7:    return 8'h00;
            14:      return 8'h1F;
            23:      return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] img(int i);
        if (i >= NREG) return 8'h00;
        if (i == 1) return model[1] | {3'b000, strap};
        if (i == 6 || i == 7) return 8'h01;
        return model[i];
    endfunction

    task automatic apply(int idx, logic [7:0] d);
        if (idx < NREG) model[idx] = (model[idx] & ~mask_of(idx)) | (d & mask_of(idx));
    endtask

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_bank(string tag);
        for (int i = 0; i < NREG; i++)
            check8($sformatf("%s reg%0d", tag, i), cfg[i*8 +: 8], img(i));
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_h = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic wbyte(logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; tick(Q);
            scl = 1'b1;   tick(2*Q);
            scl = 1'b0;
        end
        sda_h = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        a = line;     tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic rbyte(logic nack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = line; tick(Q);
            scl = 1'b0;
        end
        tick(1);
        sda_h = nack; tick(Q);
        scl = 1'b1;   tick(2*Q);
        scl = 1'b0;   tick(1);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic do_write(logic [7:0] n, logic [7:0] cnt, int nb);
        bus_start();
        wbyte(8'hD2, ackv[0]);
        wbyte(n, ackv[1]);
        wbyte(cnt, ackv[2]);
        for (int i = 0; i < nb; i++) wbyte(wbuf[i], ackv[3+i]);
        bus_stop();
        tick(2);
        for (int i = 0; i < nb; i++)
            if (i < int'(cnt)) apply(int'(n) + i, wbuf[i]);
    endtask

    task automatic do_read(logic [7:0] n, int nb);
        bus_start();
        wbyte(8'hD2, ackv[0]);
        wbyte(n, ackv[1]);
        bus_start();
        wbyte(8'hD3, ackv[2]);
        rbyte(1'b0, cnt_rd);
        for (int i = 0; i < nb; i++) rbyte(i == nb-1, rbuf[i]);
        bus_stop();
        tick(2);
    endtask

    task automatic check_acks(string tag, int upto);
        for (int i = 0; i < upto; i++)
            check8($sformatf("%s ack%0d", tag, i), {7'b0, ackv[i]}, 8'h00);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        model[8] = 8'h0F;
        tick(5);
        rst = 1'b0;
        tick(3);

        // R12 R5 R6 R7: reset image
        check_bank("R12 reset");

        // R5 R4: default count byte and first registers
        do_read(8'd0, 3);
        check_acks("R1 read", 3);
        check8("R5 default count", cnt_rd, 8'h0F);
        for (int i = 0; i < 3; i++) check8($sformatf("R4 read reg%0d", i), rbuf[i], img(i));

        // R2 R8 R6 R7: full sweep write
        for (int i = 0; i < NREG; i++) wbuf[i] = 8'(i*37 + 5);
        do_write(8'd0, 8'd24, 24);
        check_acks("R2 sweep", 27);
        check_bank("R2 R8 sweep");

        // R5: count register rewritten
        wbuf[0] = 8'd26;
        do_write(8'd8, 8'd1, 1);
        check8("R5 count reg", cfg[8*8 +: 8], 8'd26);

        // R4 R9: read whole bank plus two beyond
        do_read(8'd0, 26);
        check8("R4 count byte", cnt_rd, 8'd26);
        for (int i = 0; i < 26; i++) check8($sformatf("R4 R9 read idx%0d", i), rbuf[i], img(i));

        // R7: strap image is live
        strap = 5'h0A;
        tick(2);
        check8("R7 strap live", cfg[8 +: 8], img(1));

        // R9: write crossing the top of the bank
        wbuf[0] = 8'hC3; wbuf[1] = 8'h7E; wbuf[2] = 8'h11; wbuf[3] = 8'h22;
        do_write(8'd22, 8'd4, 4);
        check_acks("R9 beyond", 7);
        check_bank("R9 beyond");

        // R3: bytes past the count
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
        do_write(8'd3, 8'd2, 4);
        check_acks("R3 within", 5);
        check8("R3 nack extra0", {7'b0, ackv[5]}, 8'h01);
        check8("R3 nack extra1", {7'b0, ackv[6]}, 8'h01);
        check_bank("R3 overrun");

        // R1: foreign address ignored
        bus_start();
        wbyte(8'hA4, ackv[0]);
        wbyte(8'h00, ackv[1]);
        wbyte(8'h01, ackv[2]);
        wbyte(8'hFF, ackv[3]);
        bus_stop();
        tick(2);
        check8("R1 foreign addr nack", {7'b0, ackv[0]}, 8'h01);
        check8("R1 foreign data nack", {7'b0, ackv[3]}, 8'h01);
        check_bank("R1 foreign");

        // R10: stop after two of four bytes
        bus_start();
        wbyte(8'hD2, ackv[0]);
        wbyte(8'd10, ackv[1]);
        wbyte(8'd4, ackv[2]);
        wbyte(8'h5A, ackv[3]);
        wbyte(8'h6B, ackv[4]);
        bus_stop();
        tick(2);
        apply(10, 8'h5A);
        apply(11, 8'h6B);
        check_acks("R10 stop", 5);
        check_bank("R10 stop abort");

        // R10 R4: repeated start turns a partial write into a read
        bus_start();
        wbyte(8'hD2, ackv[0]);
        wbyte(8'd15, ackv[1]);
        wbyte(8'd3, ackv[2]);
        wbyte(8'h99, ackv[3]);
        bus_start();
        wbyte(8'hD3, ackv[4]);
        rbyte(1'b0, cnt_rd);
        rbyte(1'b1, rbuf[0]);
        bus_stop();
        tick(2);
        apply(15, 8'h99);
        check_acks("R10 restart", 5);
        check8("R10 restart count", cnt_rd, img(8));
        check8("R10 R4 next reg", rbuf[0], img(16));
        check_bank("R10 restart abort");

        // R6 R7 R8: read-only and reserved bits
        wbuf[0] = 8'hAA; wbuf[1] = 8'h55;
        do_write(8'd6, 8'd2, 2);
        check8("R6 reg6", cfg[6*8 +: 8], 8'h01);
        check8("R6 reg7", cfg[7*8 +: 8], 8'h01);
        wbuf[0] = 8'hFF;
        do_write(8'd1, 8'd1, 1);
        check8("R7 reg1", cfg[8 +: 8], {3'b111, strap});
        do_write(8'd5, 8'd1, 1);
        check8("R8 reg5", cfg[5*8 +: 8], 8'hE0);
        do_write(8'd14, 8'd1, 1);
        check8("R8 reg14", cfg[14*8 +: 8], 8'h1F);
        do_write(8'd23, 8'd1, 1);
        check8("R8 reg23", cfg[23*8 +: 8], 8'h3F);
        check_bank("R6 R8 final");

        // R11: line discipline over the whole run
        check8("R11 sda moves", 8'(sda_viol), 8'h00);

        summary();
        $finish;
    end

endmodule